// File: doc/BRIEF.md
# Parameter RAM boot initializer

This block brings a small audio signal processor into a known state after reset. When the active-low reset goes high, it runs a fixed-length start-up window. During that window it copies the default coefficient words, one per cycle, from a boot ROM into the 256-word parameter RAM. At the same time it writes zero to every word of the working data RAM. It also holds a clear strobe on the control register bank for the whole window.

The window is always the same length, 1024 clock cycles counted from the release of reset, no matter how much of it the copy and clear use. A done flag marks its end. Until done is high, host-port write requests are blocked from reaching the chip. Pulling reset low again at any point abandons the sequence, and the next release starts it again from address 0. The block expects its reset to be deasserted in step with the clock, as an upstream reset synchronizer provides.

The ROM read port is asynchronous: data for `rom_addr` is expected in the same cycle. The RAM write ports are plain write-enable, address and data groups that the RAMs capture on the rising clock edge.

Top module: `pram_boot_init`

## Requirements
- R1: Cycle 0 is the cycle between the release of reset and the first rising edge. In cycle k, for k from 1 to 256, `pram_we` is 1, `pram_addr` and `rom_addr` equal k-1, and `pram_wdata` equals `rom_rdata`. In every other cycle `pram_we` is 0.
- R2: After one complete sequence, each of the 256 parameter addresses has been written exactly once, with the ROM word at the same address.
- R3: In cycle k, for k from 1 to 512, `dram_we` is 1, `dram_addr` equals k-1 and `dram_wdata` is 0. In every other cycle `dram_we` is 0. As a result, each data RAM word is written with zero exactly once.
- R4: `regs_clr` is 1 while reset is asserted and in every cycle before done. It is 0 once `init_done` is 1.
- R5: `init_done` is 0 during reset and for the first 1024 rising edges after release. It goes to 1 on the 1024th rising edge.
- R6: Once `init_done` is 1, it stays 1 until reset is asserted. No RAM write occurs while it is 1.
- R7: `host_wr_en` equals `host_wr_req` when `init_done` is 1, and is 0 otherwise.
- R8: Asserting reset during the sequence immediately stops all RAM writes and clears `init_done`, without waiting for a clock edge. The next release restarts the full 1024-cycle sequence from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| rom_addr | output | 8 | Boot ROM read address |
| rom_rdata | input | 24 | Boot ROM read data, same-cycle |
| pram_we | output | 1 | Parameter RAM write enable |
| pram_addr | output | 8 | Parameter RAM write address |
| pram_wdata | output | 24 | Parameter RAM write data |
| dram_we | output | 1 | Data RAM write enable |
| dram_addr | output | 9 | Data RAM write address |
| dram_wdata | output | 24 | Data RAM write data (always zero) |
| regs_clr | output | 1 | Control register bank clear strobe |
| init_done | output | 1 | Initialization complete; low means busy |
| host_wr_req | input | 1 | Host-port write request |
| host_wr_en | output | 1 | Gated host write enable |

## Verification
The bench checks every cycle of the 1024-cycle window and predicts each expected value from the cycle index. This catches an off-by-one in the counter, which would raise done one edge early or late. It also catches a copy that starts at cycle 0 or runs a word too long, which would write an address twice or leave address 255 unloaded. A shadow model of both RAMs exposes a data clear that stops at the parameter depth and leaves the upper 256 data words uncleared. An abort at cycle 300 shows whether a restart resumes from the old count instead of address 0. Host requests toggled throughout the window reveal a gate that opens while the block is still busy.

// File: rtl/pinit_pkg.sv
package pinit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } init_state_e;

endpackage

// File: rtl/pinit_cycle_ctr.sv
module pinit_cycle_ctr
  import pinit_pkg::*;
#(
  parameter int INIT_CYCLES = 1024,
  localparam int CNT_W      = $clog2(INIT_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             done
);

  // cycle 0 is the wake-up cycle in IDLE; RUN covers the remaining cycles
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_CYCLES - 2);

  init_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        state_d = ST_RUN;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_RUN: begin
        if (cnt_q == LAST) begin
          state_d = ST_DONE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign run  = (state_q == ST_RUN);
  assign done = (state_q == ST_DONE);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != LAST) |=> (run && cnt == $past(cnt) + 1'b1)); // R5

endmodule

// File: rtl/pinit_addr_gen.sv
module pinit_addr_gen #(
  parameter int DEPTH  = 256,
  parameter int CNT_W  = 10,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  output logic             we,
  output logic [AW-1:0]    addr
);

  localparam logic [CNT_W:0] LIMIT = (CNT_W + 1)'(DEPTH);

  assign we   = run && ({1'b0, cnt} < LIMIT);
  assign addr = cnt[AW-1:0];

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $past(we)) |-> (addr == $past(addr) + 1'b1)); // R1

  AST_FIRST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !$past(we)) |-> (addr == '0)); // R8

endmodule

// File: rtl/pram_boot_init.sv
module pram_boot_init #(
  parameter int PARAM_DEPTH = 256,
  parameter int DATA_DEPTH  = 512,
  parameter int WORD_W      = 24,
  parameter int INIT_CYCLES = 1024,
  localparam int PA_W       = $clog2(PARAM_DEPTH),
  localparam int DA_W       = $clog2(DATA_DEPTH),
  localparam int CNT_W      = $clog2(INIT_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PA_W-1:0]   rom_addr,
  input  logic [WORD_W-1:0] rom_rdata,
  output logic              pram_we,
  output logic [PA_W-1:0]   pram_addr,
  output logic [WORD_W-1:0] pram_wdata,
  output logic              dram_we,
  output logic [DA_W-1:0]   dram_addr,
  output logic [WORD_W-1:0] dram_wdata,
  output logic              regs_clr,
  output logic              init_done,
  input  logic              host_wr_req,
  output logic              host_wr_en
);

  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             done;

  pinit_cycle_ctr #(.INIT_CYCLES(INIT_CYCLES)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (cnt),
    .run  (run),
    .done (done)
  );

  // parameter copy and data clear share the counter and run side by side
  pinit_addr_gen #(.DEPTH(PARAM_DEPTH), .CNT_W(CNT_W)) u_pgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .cnt  (cnt),
    .we   (pram_we),
    .addr (pram_addr)
  );

  pinit_addr_gen #(.DEPTH(DATA_DEPTH), .CNT_W(CNT_W)) u_dgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .cnt  (cnt),
    .we   (dram_we),
    .addr (dram_addr)
  );

  assign rom_addr   = pram_addr;
  assign pram_wdata = rom_rdata;
  assign dram_wdata = '0;
  assign regs_clr   = !done;
  assign init_done  = done;
  assign host_wr_en = host_wr_req && done;

  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (!pram_we && !dram_we)); // R6

  AST_COPY_INSIDE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pram_we |-> (dram_we && dram_addr == DA_W'(pram_addr))); // R3

endmodule

// File: tb/pram_boot_init_tb_top.sv
module pram_boot_init_tb_top;

  localparam int PD = 256;
  localparam int DD = 512;
  localparam int NC = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rom_addr;
  logic [23:0] rom_rdata;
  logic        pram_we, dram_we, regs_clr, init_done, host_wr_en;
  logic [7:0]  pram_addr;
  logic [8:0]  dram_addr;
  logic [23:0] pram_wdata, dram_wdata;
  logic        host_wr_req = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [23:0] pmem [PD];
  int          pcnt [PD];
  logic [23:0] dmem [DD];
  int          dcnt [DD];

  always #10 clk = ~clk;

  function automatic logic [23:0] rom_f(int a);
    return 24'((a * 40503) ^ (a << 12) ^ 24'h05A5A5);
  endfunction

  assign rom_rdata = rom_f(int'(rom_addr));

  pram_boot_init dut_i (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .pram_we(pram_we), .pram_addr(pram_addr), .pram_wdata(pram_wdata),
    .dram_we(dram_we), .dram_addr(dram_addr), .dram_wdata(dram_wdata),
    .regs_clr(regs_clr), .init_done(init_done),
    .host_wr_req(host_wr_req), .host_wr_en(host_wr_en)
  );

  always @(posedge clk) begin
    if (pram_we) begin
      pmem[pram_addr] <= pram_wdata;
      pcnt[pram_addr] <= pcnt[pram_addr] + 1;
    end
    if (dram_we) begin
      dmem[dram_addr] <= dram_wdata;
      dcnt[dram_addr] <= dcnt[dram_addr] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int a = 0; a < PD; a++) begin pcnt[a] = 0; pmem[a] = '0; end
    for (int a = 0; a < DD; a++) begin dcnt[a] = 0; dmem[a] = 24'hFFFFFF; end
  endtask

  // check one cycle of the window; k is the cycle index after release
  task automatic check_cycle(int k);
    bit pw = (k >= 1 && k <= PD);
    bit dw = (k >= 1 && k <= DD);
    host_wr_req = k[0];
    #1;
    chk(pram_we == pw, "R1", "pram_we", int'(pram_we), int'(pw));
    if (pw) begin
      chk(pram_addr == 8'(k - 1), "R1", "pram_addr", int'(pram_addr), k - 1);
      chk(rom_addr == 8'(k - 1), "R1", "rom_addr", int'(rom_addr), k - 1);
      chk(pram_wdata == rom_f(k - 1), "R1", "pram_wdata",
          int'(pram_wdata), int'(rom_f(k - 1)));
    end
    chk(dram_we == dw, "R3", "dram_we", int'(dram_we), int'(dw));
    if (dw) begin
      chk(dram_addr == 9'(k - 1), "R3", "dram_addr", int'(dram_addr), k - 1);
      chk(dram_wdata == '0, "R3", "dram_wdata", int'(dram_wdata), 0);
    end
    chk(init_done == 1'b0, "R5", "init_done early", int'(init_done), 0);
    chk(regs_clr == 1'b1, "R4", "regs_clr busy", int'(regs_clr), 1);
    chk(host_wr_en == 1'b0, "R7", "host_wr_en busy", int'(host_wr_en), 0);
  endtask

  task automatic full_sweep();
    for (int k = 0; k < NC; k++) begin
      check_cycle(k);
      @(posedge clk);
      @(negedge clk);
    end
    for (int j = 0; j < 40; j++) begin
      host_wr_req = j[0];
      #1;
      chk(init_done == 1'b1, "R5", "init_done after window", int'(init_done), 1);
      chk(!pram_we && !dram_we, "R6", "write after done",
          int'({pram_we, dram_we}), 0);
      chk(regs_clr == 1'b0, "R4", "regs_clr after done", int'(regs_clr), 0);
      chk(host_wr_en == host_wr_req, "R7", "host_wr_en open",
          int'(host_wr_en), int'(host_wr_req));
      @(posedge clk);
      @(negedge clk);
    end
    for (int a = 0; a < PD; a++) begin
      chk(pcnt[a] == 1, "R2", "param write count", pcnt[a], 1);
      chk(pmem[a] == rom_f(a), "R2", "param word", int'(pmem[a]), int'(rom_f(a)));
    end
    for (int a = 0; a < DD; a++) begin
      chk(dcnt[a] == 1 && dmem[a] == '0, "R3", "data word cleared once",
          int'(dmem[a]), 0);
    end
  endtask

  initial begin
    clear_model();
    host_wr_req = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(init_done == 1'b0, "R5", "done in reset", int'(init_done), 0);
    chk(regs_clr == 1'b1, "R4", "regs_clr in reset", int'(regs_clr), 1);
    chk(!pram_we && !dram_we, "R1", "write in reset", int'({pram_we, dram_we}), 0);
    chk(host_wr_en == 1'b0, "R7", "host_wr_en in reset", int'(host_wr_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    full_sweep();

    // R8: abort in the middle of the window, then restart
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(init_done == 1'b0, "R8", "done cleared by reset", int'(init_done), 0);
    @(negedge clk);
    clear_model();
    rst_n = 1'b1;
    for (int k = 0; k < 300; k++) begin
      check_cycle(k);
      @(posedge clk);
      @(negedge clk);
    end
    #5;
    rst_n = 1'b0;
    #1;
    chk(!pram_we && !dram_we, "R8", "writes stop on abort",
        int'({pram_we, dram_we}), 0);
    chk(regs_clr == 1'b1 && init_done == 1'b0, "R8", "state on abort",
        int'(init_done), 0);
    repeat (3) @(negedge clk);
    clear_model();
    rst_n = 1'b1;
    full_sweep();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule